// File: doc/BRIEF.md
# Open-Drain Multiplexed Address/Data Port

This block is an 8-bit bidirectional pad port with two jobs. In its I/O role, software writes a port data register and each bit drives its pad as an open-drain output. A 0 turns the pull-down on. A 1 releases the pad, so the pad can also serve as an input. Software reads live pad levels through a separate pin register, which samples the pads through a two-flop synchronizer.

In its bus role, an external bus controller raises an override request. For as long as the request is held, the controller's address/data bits go onto the pads in place of the register value. After the override ends, the pads return to whatever the data register holds. The bus cycle never alters the register.

A strap input forces the port into bus-only mode. In that mode the register has no effect on the pads, and the pads float whenever no override is present. Any register access aimed at one of the port's two addresses is passed out as an external bus request at that same address.

Register accesses use a valid/ready handshake:
- An access is accepted on a clock edge where `reg_valid` and `reg_ready` are both high.
- The requester must hold `reg_valid`, `reg_write`, `reg_addr` and `reg_wdata` steady until the access is accepted.
- In I/O mode `reg_ready` is always high.
- In bus-only mode, an access that hits one of the port's addresses takes its ready from `ext_ready`. That access completes only when the external side accepts it.

Top module: `odp_port`

## Requirements
- R1: After reset the data register holds 0xFF, every `pad_oe` bit is 0, and a read of the pin register returns 0xFF until synchronized pad values arrive.
- R2: In I/O mode with no override, each pad follows the open-drain truth table. A data bit of 0 gives `pad_oe`=1 and `pad_do`=0. A data bit of 1 gives `pad_oe`=0. `pad_do` is never 1 while `pad_oe` is 1.
- R3: An accepted write to address 0x1FFD (the data register) updates the register at that edge, and the pads reflect it from that edge on. `reg_rdata` at 0x1FFD returns the stored value.
- R4: `reg_rdata` at address 0x1FFE (the pin register) returns `pad_di` as it stood before the second-to-last clock edge, i.e. after two register stages.
- R5: While `ovr_active` is 1, `pad_do` equals `ovr_ad`. `pad_oe` is all ones when `ovr_drive`=1 (address or write-data phase) and all zeros when `ovr_drive`=0 (read-data phase).
- R6: When `ovr_active` falls, the pads return to the register's open-drain state. The register is not changed by the override. A write accepted during the override is stored at once and appears on the pads only after the override ends.
- R7: With `strap`=1 and no override, every `pad_oe` bit is 0 (the bus floats).
- R8: With `strap`=1, an access to 0x1FFD or 0x1FFE raises `ext_valid` in the same cycle, with `ext_addr`, `ext_write` and `ext_wdata` equal to the request. The data register is left unchanged.
- R9: An access to any other address is accepted at once (`reg_ready`=1). It raises no `ext_valid`, changes nothing, and `reg_rdata` reads 0.
- R10: With `strap`=1, `reg_ready` follows `ext_ready` for a hit access. A stalled write is neither lost nor applied locally. With `strap`=0, `ext_valid` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap | input | 1 | Forces bus-only mode when 1 |
| reg_valid | input | 1 | Register access request valid |
| reg_ready | output | 1 | Register access accepted |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 16 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (I/O mode) |
| ext_valid | output | 1 | Redirected external bus request |
| ext_ready | input | 1 | External side accepts the request |
| ext_write | output | 1 | Direction of the redirected request |
| ext_addr | output | 16 | Address of the redirected request |
| ext_wdata | output | 8 | Write data of the redirected request |
| ovr_active | input | 1 | Bus controller owns the pads |
| ovr_drive | input | 1 | 1 = drive the pads (address/write data), 0 = receive |
| ovr_ad | input | 8 | Address/data bits for the pads |
| pad_oe | output | 8 | Per-pad output enable (pull-down or bus drive) |
| pad_do | output | 8 | Per-pad output value |
| pad_di | input | 8 | Per-pad input level |

## Verification
The bench covers override exit with and without a write made during the override. A design that let the bus cycle overwrite the register, or that put the new write on the pads too early, shows the wrong `pad_oe` there.

It covers strap-mode writes under back-pressure. A design that applied the write locally, or dropped the request while `ext_ready` was low, leaves a wrong register value once the strap is released.

It checks the pin register's latency exactly two edges after a pad change. It also checks the read-data phase of an override, where a port that kept driving would fight the incoming data.

// File: rtl/odp_pkg.sv
package odp_pkg;
  localparam int unsigned PORT_W   = 8;
  localparam int unsigned ADR_W    = 16;
  localparam logic [15:0] DATA_ADR = 16'h1FFD;
  localparam logic [15:0] PIN_ADR  = 16'h1FFE;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_DATA = 2'd1,
    SEL_PIN  = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/odp_sync.sv
module odp_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= '1;
        else if (s == 0) chain[s] <= d;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/odp_regs.sv
module odp_regs
  import odp_pkg::*;
#(
  parameter int unsigned      W        = PORT_W,
  parameter int unsigned      AW       = ADR_W,
  parameter logic [AW-1:0]    DATA_A   = DATA_ADR,
  parameter logic [AW-1:0]    PIN_A    = PIN_ADR
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strap,
  input  logic          reg_valid,
  output logic          reg_ready,
  input  logic          reg_write,
  input  logic [AW-1:0] reg_addr,
  input  logic [W-1:0]  reg_wdata,
  output logic [W-1:0]  reg_rdata,
  output logic          ext_valid,
  input  logic          ext_ready,
  output logic          ext_write,
  output logic [AW-1:0] ext_addr,
  output logic [W-1:0]  ext_wdata,
  input  logic [W-1:0]  pin_sync,
  output logic [W-1:0]  data_q
);
  reg_sel_e sel;
  logic     hit;

  always_comb begin
    if (reg_addr == DATA_A)     sel = SEL_DATA;
    else if (reg_addr == PIN_A) sel = SEL_PIN;
    else                        sel = SEL_NONE;
  end

  assign hit       = (sel != SEL_NONE);
  assign ext_valid = reg_valid && strap && hit;
  assign ext_write = reg_write;
  assign ext_addr  = reg_addr;
  assign ext_wdata = reg_wdata;
  assign reg_ready = (strap && hit) ? ext_ready : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) data_q <= '1;
    else if (reg_valid && reg_write && !strap && sel == SEL_DATA)
      data_q <= reg_wdata;
  end

  always_comb begin
    unique case (sel)
      SEL_DATA: reg_rdata = strap ? '0 : data_q;
      SEL_PIN:  reg_rdata = strap ? '0 : pin_sync;
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/odp_padmux.sv
module odp_padmux #(
  parameter int unsigned W = 8
) (
  input  logic         strap,
  input  logic         ovr_active,
  input  logic         ovr_drive,
  input  logic [W-1:0] ovr_ad,
  input  logic [W-1:0] data_q,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] pad_do
);
  logic bus_own;
  assign bus_own = ovr_active;

  genvar b;
  generate
    for (b = 0; b < W; b++) begin : g_bit
      always_comb begin
        if (bus_own) begin
          pad_oe[b] = ovr_drive;
          pad_do[b] = ovr_ad[b];
        end else if (strap) begin
          pad_oe[b] = 1'b0;
          pad_do[b] = 1'b0;
        end else begin
          pad_oe[b] = ~data_q[b];
          pad_do[b] = 1'b0;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/odp_port.sv
module odp_port
  import odp_pkg::*;
#(
  parameter int unsigned   W      = PORT_W,
  parameter int unsigned   AW     = ADR_W,
  parameter logic [AW-1:0] DATA_A = DATA_ADR,
  parameter logic [AW-1:0] PIN_A  = PIN_ADR,
  parameter int unsigned   SYNC_N = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strap,
  input  logic          reg_valid,
  output logic          reg_ready,
  input  logic          reg_write,
  input  logic [AW-1:0] reg_addr,
  input  logic [W-1:0]  reg_wdata,
  output logic [W-1:0]  reg_rdata,
  output logic          ext_valid,
  input  logic          ext_ready,
  output logic          ext_write,
  output logic [AW-1:0] ext_addr,
  output logic [W-1:0]  ext_wdata,
  input  logic          ovr_active,
  input  logic          ovr_drive,
  input  logic [W-1:0]  ovr_ad,
  output logic [W-1:0]  pad_oe,
  output logic [W-1:0]  pad_do,
  input  logic [W-1:0]  pad_di
);
  logic [W-1:0] pin_sync;
  logic [W-1:0] data_q;

  odp_sync #(.W(W), .STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_di), .q(pin_sync)
  );

  odp_regs #(.W(W), .AW(AW), .DATA_A(DATA_A), .PIN_A(PIN_A)) u_regs (
    .clk(clk), .rst_n(rst_n), .strap(strap),
    .reg_valid(reg_valid), .reg_ready(reg_ready), .reg_write(reg_write),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ext_valid(ext_valid), .ext_ready(ext_ready), .ext_write(ext_write),
    .ext_addr(ext_addr), .ext_wdata(ext_wdata),
    .pin_sync(pin_sync), .data_q(data_q)
  );

  odp_padmux #(.W(W)) u_mux (
    .strap(strap), .ovr_active(ovr_active), .ovr_drive(ovr_drive),
    .ovr_ad(ovr_ad), .data_q(data_q), .pad_oe(pad_oe), .pad_do(pad_do)
  );
endmodule

// File: rtl/odp_port_chk.sv
module odp_port_chk #(
  parameter int unsigned   W      = 8,
  parameter int unsigned   AW     = 16,
  parameter logic [AW-1:0] DATA_A = 16'h1FFD,
  parameter logic [AW-1:0] PIN_A  = 16'h1FFE
) (
  input logic          clk,
  input logic          rst_n,
  input logic          strap,
  input logic          reg_valid,
  input logic          reg_ready,
  input logic          reg_write,
  input logic [AW-1:0] reg_addr,
  input logic [W-1:0]  reg_wdata,
  input logic          ext_valid,
  input logic [AW-1:0] ext_addr,
  input logic          ovr_active,
  input logic          ovr_drive,
  input logic [W-1:0]  ovr_ad,
  input logic [W-1:0]  pad_oe,
  input logic [W-1:0]  pad_do
);
  // R3
  write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!strap && !ovr_active &&
     $past(rst_n && reg_valid && reg_write && !strap && reg_addr == DATA_A))
    |-> pad_oe == ~$past(reg_wdata));

  // R2
  open_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!strap && !ovr_active) |-> (pad_oe & pad_do) == '0);

  // R5
  ovr_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_active |-> (pad_do == ovr_ad &&
                    pad_oe == (ovr_drive ? {W{1'b1}} : {W{1'b0}})));

  // R7
  strap_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strap && !ovr_active) |-> pad_oe == '0);

  // R8
  redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strap && reg_valid && (reg_addr == DATA_A || reg_addr == PIN_A))
    |-> (ext_valid && ext_addr == reg_addr));

  // R10
  no_ext_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_valid |-> strap);

  // R9
  miss_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_valid && reg_addr != DATA_A && reg_addr != PIN_A)
    |-> (reg_ready && !ext_valid));
endmodule

bind odp_port odp_port_chk #(.W(W), .AW(AW), .DATA_A(DATA_A), .PIN_A(PIN_A)) u_chk (
  .clk(clk), .rst_n(rst_n), .strap(strap), .reg_valid(reg_valid),
  .reg_ready(reg_ready), .reg_write(reg_write), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .ext_valid(ext_valid), .ext_addr(ext_addr),
  .ovr_active(ovr_active), .ovr_drive(ovr_drive), .ovr_ad(ovr_ad),
  .pad_oe(pad_oe), .pad_do(pad_do)
);

// File: tb/test_odp_port.sv
module test_odp_port;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] A_DATA = 16'h1FFD;
  localparam logic [15:0] A_PIN  = 16'h1FFE;

  logic clk = 0, rst_n = 0, strap = 0;
  logic reg_valid = 0, reg_write = 0, ext_ready = 0;
  logic [15:0] reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic ovr_active = 0, ovr_drive = 0;
  logic [7:0] ovr_ad = '0;
  logic [7:0] frc_en = '0, frc_val = '0;
  logic reg_ready, ext_valid, ext_write;
  logic [7:0] reg_rdata, ext_wdata, pad_oe, pad_do, pad_di;
  logic [15:0] ext_addr;
  int n_run = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // pad model: pulled up, optionally forced by an outside driver
  always_comb
    for (int i = 0; i < 8; i++)
      pad_di[i] = pad_oe[i] ? pad_do[i] : (frc_en[i] ? frc_val[i] : 1'b1);

  odp_port i_odp_port (
    .clk(clk), .rst_n(rst_n), .strap(strap), .reg_valid(reg_valid),
    .reg_ready(reg_ready), .reg_write(reg_write), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_valid(ext_valid),
    .ext_ready(ext_ready), .ext_write(ext_write), .ext_addr(ext_addr),
    .ext_wdata(ext_wdata), .ovr_active(ovr_active), .ovr_drive(ovr_drive),
    .ovr_ad(ovr_ad), .pad_oe(pad_oe), .pad_do(pad_do), .pad_di(pad_di)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    reg_valid = 1; reg_write = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_valid = 0; reg_write = 0;
  endtask

  task automatic rd_now(logic [15:0] a, output logic [7:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    @(negedge clk);
    chk("R1 oe", pad_oe, 8'h00);
    rd_now(A_DATA, d); chk("R1 data", d, 8'hFF);
    rd_now(A_PIN, d);  chk("R1 pin", d, 8'hFF);
  endtask

  task automatic t_open_drain;
    logic [7:0] d;
    wr(A_DATA, 8'hA5);
    chk("R3 oe", pad_oe, 8'h5A);
    chk("R2 do", pad_do, 8'h00);
    rd_now(A_DATA, d); chk("R3 readback", d, 8'hA5);
    wr(A_DATA, 8'h00);
    chk("R2 all low", pad_oe, 8'hFF);
    wr(A_DATA, 8'hFF);
    chk("R2 release", pad_oe, 8'h00);
  endtask

  task automatic t_pin_sync;
    logic [7:0] d;
    @(negedge clk);
    frc_en = 8'hFF; frc_val = 8'h3C;
    @(posedge clk); @(negedge clk);
    rd_now(A_PIN, d); chk("R4 one edge", d, 8'hFF);
    @(posedge clk); @(negedge clk);
    rd_now(A_PIN, d); chk("R4 two edges", d, 8'h3C);
    frc_en = '0;
    @(posedge clk); @(posedge clk); @(negedge clk);
  endtask

  task automatic t_override;
    logic [7:0] d;
    wr(A_DATA, 8'hF0);
    @(negedge clk);
    ovr_active = 1; ovr_drive = 1; ovr_ad = 8'h96; #1;
    chk("R5 drive oe", pad_oe, 8'hFF);
    chk("R5 drive do", pad_do, 8'h96);
    @(negedge clk);
    ovr_drive = 0; #1;
    chk("R5 read phase oe", pad_oe, 8'h00);
    @(negedge clk);
    ovr_active = 0; #1;
    chk("R6 restore", pad_oe, 8'h0F);
    rd_now(A_DATA, d); chk("R6 reg kept", d, 8'hF0);
    @(negedge clk);
    ovr_active = 1; ovr_drive = 1; ovr_ad = 8'h11;
    wr(A_DATA, 8'h3C);
    chk("R6 hidden during ovr", pad_oe, 8'hFF);
    ovr_active = 0; #1;
    chk("R6 new after ovr", pad_oe, 8'hC3);
  endtask

  task automatic t_strap;
    logic [7:0] d;
    @(negedge clk);
    strap = 1; ext_ready = 0; #1;
    chk("R7 float", pad_oe, 8'h00);
    reg_valid = 1; reg_write = 1; reg_addr = A_DATA; reg_wdata = 8'h00; #1;
    chk("R8 ext_valid", {31'd0, ext_valid}, 32'd1);
    chk("R8 ext_addr", ext_addr, A_DATA);
    chk("R8 ext_wdata", ext_wdata, 8'h00);
    chk("R10 stalled", {31'd0, reg_ready}, 32'd0);
    @(posedge clk); @(negedge clk);
    chk("R10 held", {31'd0, ext_valid}, 32'd1);
    ext_ready = 1; #1;
    chk("R10 ready follows", {31'd0, reg_ready}, 32'd1);
    @(posedge clk); @(negedge clk);
    reg_valid = 0; reg_write = 0; ext_ready = 0;
    reg_addr = A_PIN; reg_valid = 1; #1;
    chk("R8 pin redirect", {ext_valid, ext_write, ext_addr}, {1'b1, 1'b0, A_PIN});
    reg_valid = 0;
    ovr_active = 1; ovr_drive = 1; ovr_ad = 8'h5A; #1;
    chk("R7 ovr in strap", pad_oe, 8'hFF);
    @(negedge clk);
    ovr_active = 0; strap = 0; #1;
    chk("R8 reg untouched", pad_oe, 8'hC3);
    rd_now(A_DATA, d); chk("R8 readback", d, 8'h3C);
  endtask

  task automatic t_miss;
    logic [7:0] d;
    @(negedge clk);
    reg_valid = 1; reg_write = 1; reg_addr = 16'h1FFC; reg_wdata = 8'h00; #1;
    chk("R9 ready", {31'd0, reg_ready}, 32'd1);
    chk("R9 rdata", reg_rdata, 8'h00);
    @(posedge clk); @(negedge clk);
    reg_valid = 0; reg_write = 0;
    chk("R9 no change", pad_oe, 8'hC3);
    chk("R10 no ext local", {31'd0, ext_valid}, 32'd0);
    rd_now(A_DATA, d); chk("R9 reg kept", d, 8'h3C);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    t_reset;
    t_open_drain;
    t_pin_sync;
    t_override;
    t_strap;
    t_miss;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule